// File: doc/BRIEF.md
# Interrupt Level and Vector Controller

This block ranks up to 128 peripheral interrupt request lines by programmable priority level. Adjacent sources share one level register, so 64 registers cover 128 lines. On every clock the block selects the pending, enabled source with the highest priority and registers three results for the CPU: the winning level, the vector number and the 32-bit address of the vector table entry to fetch. It raises its interrupt output only when the winning level is strictly below the mask level the CPU currently holds.

The vector table base is held in a relocatable register. The table runs downward from the base: entry `n` sits at `base + 0x3FC - 4*n`. The addresses of the reset and mode entries are constant outputs and do not follow the base. Software reaches the level registers and the base through a small synchronous write port and a combinational read port that share one address.

Top module: `ivc_top`

## Requirements
- R1: After reset the table base reads 0x000FFC00 at register address 64.
- R2: A write to the table base stores the written word with bits 1:0 cleared. Any result above 0xFFFFFC00 is stored as 0xFFFFFC00.
- R3: `irq_vaddr_o` equals table base + 0x3FC - 4 × `irq_vector_o`, modulo 2^32.
- R4: `rst_vaddr_o` is always 0x000FFFFC and `mode_vaddr_o` is always 0x000FFFF8, whatever the table base holds.
- R5: Level registers sit at addresses 0 to 63 and read 0x1F after reset. A write stores only data bits 3:0. Bit 4 always reads 1 and bits 31:5 always read 0, so writing 0x00 reads back 0x10.
- R6: Source k uses level register k/2 and reports vector number 16 + k.
- R7: A level of 31 disables both sources of its pair. Their requests never win and never raise `irq_o`.
- R8: A lower level value has higher priority. Between equal levels the lower vector number wins.
- R9: `irq_o` is 1 only when the winning level is strictly less than `cpu_mask_i`. All outputs are registered and reflect the inputs one clock edge earlier.
- R10: With no enabled pending request, `irq_o` is 0, `irq_level_o` is 31 and `irq_vector_o` is 0.
- R11: Addresses 65 to 127 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 7 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_we_i | input | 1 | Write enable |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| src_req_i | input | 128 | Peripheral request lines, bit k = source k |
| cpu_mask_i | input | 5 | Current CPU mask level |
| irq_o | output | 1 | Interrupt request to the CPU |
| irq_level_o | output | 5 | Winning level |
| irq_vector_o | output | 8 | Winning vector number |
| irq_vaddr_o | output | 32 | Vector fetch address of the winner |
| rst_vaddr_o | output | 32 | Fixed reset vector address |
| mode_vaddr_o | output | 32 | Fixed mode vector address |

## Verification
The hardest cases to reach from the ports are ties and boundaries. One is two requests at the same level, inside one register pair or across pairs, where only the vector number decides the winner. The other is a winning level exactly equal to the mask. Random stimulus rarely produces either. Directed cases set up a shared-level pair with both sources requesting and step the mask across the winning level. Sparse random request vectors with few distinct level values then drive many equal-level contests.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int unsigned LVL_W = 5;
  localparam int unsigned VEC_W = 8;
  localparam int unsigned VEC_FIRST = 16;
  localparam logic [LVL_W-1:0] LVL_OFF = 5'd31;
  localparam logic [31:0] BASE_RESET = 32'h000F_FC00;
  localparam logic [31:0] BASE_MAX   = 32'hFFFF_FC00;
  localparam logic [31:0] TABLE_TOP  = 32'h0000_03FC;
  localparam logic [31:0] RST_VADDR  = 32'h000F_FFFC;
  localparam logic [31:0] MODE_VADDR = 32'h000F_FFF8;
endpackage

// File: rtl/ivc_lvl_regs.sv
module ivc_lvl_regs #(
  parameter int unsigned NUM_REG = 64,
  parameter int unsigned ADDR_W  = 7
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [3:0]                      wdata_i,
  output logic [NUM_REG-1:0][ivc_pkg::LVL_W-1:0] lvl_o
);
  genvar g;
  generate
    for (g = 0; g < NUM_REG; g++) begin : g_reg
      logic [3:0] lo_q;
      logic [3:0] lo_d;
      logic       hit;

      assign hit = we_i && (addr_i == ADDR_W'(g));

      always_comb begin
        lo_d = lo_q;
        if (hit) lo_d = wdata_i;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lo_q <= 4'hF;
        else        lo_q <= lo_d;
      end

      assign lvl_o[g] = {1'b1, lo_q};
    end
  endgenerate
endmodule

// File: rtl/ivc_arb.sv
module ivc_arb #(
  parameter int unsigned NUM_SRC = 128,
  parameter int unsigned NUM_REG = NUM_SRC / 2,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [NUM_SRC-1:0]                     req_i,
  input  logic [NUM_REG-1:0][ivc_pkg::LVL_W-1:0] lvl_i,
  output logic                                   valid_o,
  output logic [ivc_pkg::LVL_W-1:0]              win_lvl_o,
  output logic [IDX_W-1:0]                       win_idx_o
);
  import ivc_pkg::*;

  logic [LVL_W-1:0] best_lvl;
  logic [IDX_W-1:0] best_idx;

  // Scan from the top down with <=, so the lowest index wins a tie.
  always_comb begin
    logic [LVL_W-1:0] eff;
    best_lvl = LVL_OFF;
    best_idx = '0;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      eff = req_i[k] ? lvl_i[k/2] : LVL_OFF;
      if (eff <= best_lvl) begin
        best_lvl = eff;
        best_idx = k[IDX_W-1:0];
      end
    end
  end

  assign valid_o   = (best_lvl != LVL_OFF);
  assign win_lvl_o = best_lvl;
  assign win_idx_o = best_idx;

  AST_WIN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> req_i[win_idx_o]); // R8
  AST_IDLE_NO_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == '0) |-> !valid_o); // R10
endmodule

// File: rtl/ivc_top.sv
module ivc_top #(
  parameter int unsigned NUM_SRC = 128,
  localparam int unsigned NUM_REG = NUM_SRC / 2,
  localparam int unsigned ADDR_W  = $clog2(NUM_REG) + 1,
  localparam int unsigned IDX_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  input  logic               reg_we_i,
  output logic [31:0]        reg_rdata_o,
  input  logic [NUM_SRC-1:0] src_req_i,
  input  logic [4:0]         cpu_mask_i,
  output logic               irq_o,
  output logic [4:0]         irq_level_o,
  output logic [7:0]         irq_vector_o,
  output logic [31:0]        irq_vaddr_o,
  output logic [31:0]        rst_vaddr_o,
  output logic [31:0]        mode_vaddr_o
);
  import ivc_pkg::*;

  localparam logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(NUM_REG);

  logic [NUM_REG-1:0][LVL_W-1:0] lvl;
  logic                          win_valid;
  logic [LVL_W-1:0]              win_lvl;
  logic [IDX_W-1:0]              win_idx;

  ivc_lvl_regs #(.NUM_REG(NUM_REG), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i[3:0]),
    .lvl_o   (lvl)
  );

  ivc_arb #(.NUM_SRC(NUM_SRC), .NUM_REG(NUM_REG)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (src_req_i),
    .lvl_i     (lvl),
    .valid_o   (win_valid),
    .win_lvl_o (win_lvl),
    .win_idx_o (win_idx)
  );

  // Table base register
  logic [31:0] base_q, base_d, base_wr;
  logic        base_en;

  assign base_en = reg_we_i && (reg_addr_i == BASE_ADDR);

  always_comb begin
    base_wr = {reg_wdata_i[31:2], 2'b00};
    if (base_wr > BASE_MAX) base_wr = BASE_MAX;
    base_d = base_en ? base_wr : base_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= BASE_RESET;
    else        base_q <= base_d;
  end

  // Read mux
  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i < BASE_ADDR)       reg_rdata_o = {27'd0, lvl[reg_addr_i[ADDR_W-2:0]]};
    else if (reg_addr_i == BASE_ADDR) reg_rdata_o = base_q;
  end

  // Registered outputs
  logic             irq_d;
  logic [LVL_W-1:0] lvl_d;
  logic [VEC_W-1:0] vec_d;
  logic [31:0]      vaddr_d;

  always_comb begin
    irq_d   = win_valid && (win_lvl < cpu_mask_i);
    lvl_d   = win_valid ? win_lvl : LVL_OFF;
    vec_d   = win_valid ? (VEC_W'(VEC_FIRST) + VEC_W'(win_idx)) : '0;
    vaddr_d = base_q + TABLE_TOP - {22'd0, vec_d, 2'b00};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o        <= 1'b0;
      irq_level_o  <= LVL_OFF;
      irq_vector_o <= '0;
      irq_vaddr_o  <= BASE_RESET + TABLE_TOP;
    end else begin
      irq_o        <= irq_d;
      irq_level_o  <= lvl_d;
      irq_vector_o <= vec_d;
      irq_vaddr_o  <= vaddr_d;
    end
  end

  assign rst_vaddr_o  = RST_VADDR;
  assign mode_vaddr_o = MODE_VADDR;

  AST_BASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (base_q[1:0] == 2'b00) && (base_q <= BASE_MAX)); // R2
  AST_IRQ_BELOW_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_level_o < $past(cpu_mask_i))); // R9
  AST_IRQ_NOT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_level_o != LVL_OFF)); // R7
  AST_IRQ_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_vector_o >= VEC_W'(VEC_FIRST))); // R6
endmodule

// File: tb/tb_ivc_top.sv
module tb_ivc_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [6:0]   reg_addr_i = '0;
  logic [31:0]  reg_wdata_i = '0;
  logic         reg_we_i = 1'b0;
  logic [31:0]  reg_rdata_o;
  logic [127:0] src_req_i = '0;
  logic [4:0]   cpu_mask_i = '0;
  logic         irq_o;
  logic [4:0]   irq_level_o;
  logic [7:0]   irq_vector_o;
  logic [31:0]  irq_vaddr_o, rst_vaddr_o, mode_vaddr_o;

  int checks = 0;
  int errors = 0;

  logic [4:0]  lvl_m [64];
  logic [31:0] base_m;

  always #4 clk = ~clk;

  ivc_top dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk);
    reg_we_i = 1'b0;
    if (a < 7'd64) lvl_m[a] = {1'b1, d[3:0]};
    else if (a == 7'd64) base_m = ({d[31:2], 2'b00} > 32'hFFFFFC00) ? 32'hFFFFFC00 : {d[31:2], 2'b00};
  endtask

  task automatic rd_chk(input string tag, input logic [6:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr_i = a;
    #1 chk(tag, reg_rdata_o, exp);
  endtask

  task automatic outs_chk(input string tag);
    bit          ei;
    logic [4:0]  el;
    logic [7:0]  ev;
    logic [31:0] ea;
    int          bl;
    int          bi;
    bl = 31; bi = -1;
    for (int k = 0; k < 128; k++)
      if (src_req_i[k] && int'(lvl_m[k/2]) < bl) begin bl = int'(lvl_m[k/2]); bi = k; end
    ei = (bi >= 0) && (bl < int'(cpu_mask_i));
    el = 5'(bl);
    ev = (bi >= 0) ? 8'(16 + bi) : 8'd0;
    ea = base_m + 32'h3FC - {22'd0, ev, 2'b00};
    chk({tag, " R9 irq"},    {31'd0, irq_o}, {31'd0, ei});
    chk({tag, " R8 level"},  {27'd0, irq_level_o}, {27'd0, el});
    chk({tag, " R6 vector"}, {24'd0, irq_vector_o}, {24'd0, ev});
    chk({tag, " R3 vaddr"},  irq_vaddr_o, ea);
  endtask

  task automatic settle();
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h00C0FFEE);
    for (int i = 0; i < 64; i++) lvl_m[i] = 5'h1F;
    base_m = 32'h000FFC00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    rd_chk("R1 base reset", 7'd64, 32'h000FFC00);
    rd_chk("R5 reg0 reset", 7'd0, 32'h1F);
    rd_chk("R5 reg63 reset", 7'd63, 32'h1F);
    chk("R4 reset vaddr", rst_vaddr_o, 32'h000FFFFC);
    chk("R4 mode vaddr", mode_vaddr_o, 32'h000FFFF8);
    chk("R10 idle irq", {31'd0, irq_o}, 32'd0);
    chk("R10 idle level", {27'd0, irq_level_o}, 32'd31);
    chk("R10 idle vector", {24'd0, irq_vector_o}, 32'd0);

    // Level register field behaviour
    wr(7'd0, 32'h0000_0000);
    rd_chk("R5 write 0 reads 0x10", 7'd0, 32'h10);
    wr(7'd1, 32'hFFFF_FFE5);
    rd_chk("R5 upper bits dropped", 7'd1, 32'h15);
    wr(7'd0, 32'h0000_000F);
    rd_chk("R5 write 0x0F", 7'd0, 32'h1F);

    // Base register
    wr(7'd64, 32'h1234_5677);
    rd_chk("R2 base align", 7'd64, 32'h1234_5674);
    wr(7'd64, 32'hFFFF_FFFF);
    rd_chk("R2 base clamp", 7'd64, 32'hFFFF_FC00);
    chk("R4 reset vaddr after move", rst_vaddr_o, 32'h000FFFFC);
    chk("R4 mode vaddr after move", mode_vaddr_o, 32'h000FFFF8);
    wr(7'd64, 32'h0002_0000);

    // Unmapped address
    wr(7'd100, 32'h0000_0003);
    rd_chk("R11 unmapped reads 0", 7'd100, 32'h0);
    rd_chk("R11 base untouched", 7'd64, 32'h0002_0000);
    rd_chk("R11 reg36 untouched", 7'd36, 32'h1F);

    // Pair shares one level, tie goes to lower vector
    wr(7'd3, 32'h2);
    @(negedge clk);
    src_req_i = '0; src_req_i[6] = 1'b1; src_req_i[7] = 1'b1; cpu_mask_i = 5'd31;
    settle();
    chk("R8 tie in pair vector", {24'd0, irq_vector_o}, 32'd22);
    outs_chk("pair tie");
    src_req_i = '0; src_req_i[7] = 1'b1;
    settle();
    chk("R6 source 7 vector", {24'd0, irq_vector_o}, 32'd23);
    chk("R3 source 7 vaddr", irq_vaddr_o, 32'h0002_0000 + 32'h3FC - 32'd92);

    // Cross-pair tie and priority
    wr(7'd40, 32'h2);
    src_req_i = '0; src_req_i[81] = 1'b1; src_req_i[7] = 1'b1;
    settle();
    chk("R8 cross-pair tie", {24'd0, irq_vector_o}, 32'd23);
    wr(7'd40, 32'h1);
    settle();
    chk("R8 lower level wins", {24'd0, irq_vector_o}, 32'd97);

    // Disabled pair
    wr(7'd5, 32'hF);
    src_req_i = '0; src_req_i[10] = 1'b1; src_req_i[11] = 1'b1;
    settle();
    chk("R7 disabled irq", {31'd0, irq_o}, 32'd0);
    chk("R7 disabled level", {27'd0, irq_level_o}, 32'd31);
    chk("R10 disabled vector", {24'd0, irq_vector_o}, 32'd0);

    // Mask boundary and one-edge latency
    src_req_i = '0; src_req_i[7] = 1'b1; cpu_mask_i = 5'd18;
    settle();
    chk("R9 level equals mask", {31'd0, irq_o}, 32'd0);
    cpu_mask_i = 5'd19;
    @(posedge clk); @(negedge clk);
    chk("R9 one edge to raise", {31'd0, irq_o}, 32'd1);
    chk("R9 level out", {27'd0, irq_level_o}, 32'd18);

    // Random traffic with few distinct levels to force ties
    for (int it = 0; it < 400; it++) begin
      int nw;
      nw = int'($urandom_range(0, 3));
      for (int w = 0; w < nw; w++)
        wr(7'($urandom_range(0, 63)), 32'($urandom_range(12, 15)) | ($urandom & 32'hFFFF_FFF0));
      if ($urandom_range(0, 19) == 0) wr(7'd64, $urandom);
      if ($urandom_range(0, 9) == 0) wr(7'($urandom_range(65, 127)), $urandom);
      for (int k = 0; k < 128; k++) src_req_i[k] = ($urandom_range(0, 15) == 0);
      cpu_mask_i = 5'($urandom_range(12, 31));
      settle();
      outs_chk("random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule